// File: doc/BRIEF.md
# Arithmetic condition code generator

This unit turns the outcome of an integer operation into a single 2-bit condition code. The code's meaning depends on the operation, so it does not produce separate negative, zero, carry and overflow flags. A 5-bit selector names the operation and its width. Up to three 64-bit operands are presented with it: a first operand `opa_i`, a second operand `opb_i` and the operation's result `res_i`. The unit classifies these operands against the rules for that operation. It does not recompute the arithmetic. It relies on the result supplied by the datapath that performed the operation.

Every operation other than the four constants exists in a 32-bit form and a 64-bit form. For selectors 4 and above, bit 0 of the selector picks the width: 0 means 32-bit and 1 means 64-bit. A 32-bit form uses only the low 32 bits of each operand. Selectors the unit does not recognise give a zero code and raise an error flag. With the default `REG_OUT = 1`, the code and the flag are registered. They appear on the clock edge after the selector and operands are presented.

Top module: `cond_code_unit`

## Requirements
- R1: Selectors 0, 1, 2 and 3 produce a code equal to the selector value, whatever the operands hold.
- R2: Selectors 6 and 7 (signed) and 8 and 9 (unsigned) compare `opa_i` with `opb_i`. They give 0 when the operands are equal, 1 when `opa_i` is less and 2 when it is greater.
- R3: Selectors 10 and 11 compare `res_i`, read as signed, with zero. They give 0 for zero, 1 for a negative value and 2 for a positive value.
- R4: Selectors 12 and 13 (signed add) give 3 when both inputs are positive and the result is negative, or when both are negative and the result is positive. Otherwise they give 1 for a negative result, 2 for a positive result and 0 for a zero result.
- R5: Selectors 14 and 15 (signed subtract) give 3 when a positive `opa_i` and a negative `opb_i` give a negative result, or when a negative `opa_i` and a positive `opb_i` give a positive result. Otherwise they use the sign coding of R4.
- R6: Selectors 16 and 17 (unsigned add) detect a carry when `res_i` is smaller than `opa_i` or smaller than `opb_i`. The code is 0 for a zero result without carry, 1 for a nonzero result without carry, 2 for a zero result with carry and 3 for a nonzero result with carry.
- R7: Selectors 18 and 19 (unsigned subtract) give 2 when the result is zero. For a nonzero result they give 1 when `opb_i` exceeds `opa_i` and 3 otherwise, so they never give 0.
- R8: Selectors 20 and 21 (absolute value) give 3 when `res_i` is the most negative value of the width, 1 for any other nonzero value and 0 for zero. Selectors 22 and 23 (negative absolute value) give 0 for zero and 1 otherwise.
- R9: Selectors 24 and 25 (complement) give 3 for the most negative value of the width, 1 for other negative values, 2 for positive values and 0 for zero.
- R10: Selectors 4 and 5 (nonzero test) give 0 when `res_i` is zero and 1 otherwise.
- R11: A 32-bit form (selector 4 or above with bit 0 clear) ignores bits 63:32 of every operand and takes the sign from bit 31.
- R12: Selectors 26 to 31 give a code of 0 with `err_o` set for that cycle. `err_o` is clear for every valid selector.
- R13: With `REG_OUT = 1`, the code and the flag change only on the rising clock edge after the inputs are presented. While `rst_n` is low, a clock edge clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 5 | Operation and width selector |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| res_i | input | 64 | Result of the operation being classified |
| cc_o | output | 2 | Condition code |
| err_o | output | 1 | Unrecognised selector flag |

## Verification
Each operation is driven with operands that fall on the borders between its codes: equal, just below, just above, zero, and the most negative value. Each overflow case is paired with a non-overflow case whose result has the same sign, so a missing overflow term shows up as a changed code. For the 32-bit forms, the operands put distracting values in bits 63:32 or put the sign only in bit 31. The 32-bit answer and the 64-bit answer then differ, which separates a correct width choice from a unit that reads all 64 bits. Invalid selectors are applied both during reset and after it, and are followed by a valid selector, to show that the error flag lasts only as long as the bad selector.

// File: rtl/cc_gen_pkg.sv
// Package: shared selector encoding and sizes for the condition code unit.
// Assumes a selector width of 5 bits. Bit 0 of every selector from 4 upward
// gives the width (0 = narrow form, 1 = wide form).
package cc_gen_pkg;

    localparam int SEL_W    = 5;
    localparam int CC_W     = 2;
    localparam int SEL_LAST = 25;

    typedef enum logic [SEL_W-1:0] {
        CC_K0     = 5'd0,
        CC_K1     = 5'd1,
        CC_K2     = 5'd2,
        CC_K3     = 5'd3,
        CC_NZ_W   = 5'd4,
        CC_NZ_D   = 5'd5,
        CC_SCMP_W = 5'd6,
        CC_SCMP_D = 5'd7,
        CC_UCMP_W = 5'd8,
        CC_UCMP_D = 5'd9,
        CC_SZR_W  = 5'd10,
        CC_SZR_D  = 5'd11,
        CC_SADD_W = 5'd12,
        CC_SADD_D = 5'd13,
        CC_SSUB_W = 5'd14,
        CC_SSUB_D = 5'd15,
        CC_UADD_W = 5'd16,
        CC_UADD_D = 5'd17,
        CC_USUB_W = 5'd18,
        CC_USUB_D = 5'd19,
        CC_ABS_W  = 5'd20,
        CC_ABS_D  = 5'd21,
        CC_NABS_W = 5'd22,
        CC_NABS_D = 5'd23,
        CC_NEG_W  = 5'd24,
        CC_NEG_D  = 5'd25
    } cc_sel_e;

    // Codes shared by several operation classes
    localparam logic [CC_W-1:0] CODE_ZERO = 2'd0;
    localparam logic [CC_W-1:0] CODE_LOW  = 2'd1;
    localparam logic [CC_W-1:0] CODE_HIGH = 2'd2;
    localparam logic [CC_W-1:0] CODE_SPEC = 2'd3;

endpackage

// File: rtl/cc_opnd_view.sv
// Module: cc_opnd_view
// Presents one raw operand at the width chosen by the selector. It gives a
// zero-extended copy, a sign-extended copy, the sign and a zero flag.
// Assumes NW < DW. In the narrow form, bits DW-1:NW of the raw operand have
// no effect on any output.
module cc_opnd_view #(
    parameter int DW = 64,
    parameter int NW = 32
) (
    input  logic [DW-1:0] raw_i,
    input  logic          narrow_i,
    output logic [DW-1:0] zext_o,
    output logic [DW-1:0] sext_o,
    output logic          neg_o,
    output logic          zero_o
);
    localparam int UW = DW - NW;

    // Purpose: choose the view for the active width.
    always_comb begin
        if (narrow_i) begin
            zext_o = {{UW{1'b0}}, raw_i[NW-1:0]};
            sext_o = {{UW{raw_i[NW-1]}}, raw_i[NW-1:0]};
            neg_o  = raw_i[NW-1];
        end else begin
            zext_o = raw_i;
            sext_o = raw_i;
            neg_o  = raw_i[DW-1];
        end
        zero_o = (zext_o == '0);
    end
endmodule

// File: rtl/cc_relate.sv
// Module: cc_relate
// Three-way compare of two operands that are already at the right width.
// Gives 0 when they are equal, 1 when lhs < rhs and 2 when lhs > rhs.
// Assumes the signed inputs are sign-extended and the unsigned inputs are
// zero-extended copies of the same values.
module cc_relate #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] lhs_s_i,
    input  logic [DW-1:0] rhs_s_i,
    input  logic [DW-1:0] lhs_u_i,
    input  logic [DW-1:0] rhs_u_i,
    input  logic          signed_i,
    output logic [1:0]    code_o
);
    import cc_gen_pkg::*;

    logic same;
    logic below;

    // Purpose: order the operands in the chosen number system.
    always_comb begin
        same  = (lhs_u_i == rhs_u_i);
        below = signed_i ? ($signed(lhs_s_i) < $signed(rhs_s_i))
                         : (lhs_u_i < rhs_u_i);
        if (same)       code_o = CODE_ZERO;
        else if (below) code_o = CODE_LOW;
        else            code_o = CODE_HIGH;
    end
endmodule

// File: rtl/cc_arith_class.sv
// Module: cc_arith_class
// Classifies the results of add and subtract in both signed and unsigned
// forms, using the sign and zero flags of the three operands.
// Assumes all inputs come from views at the same width.
module cc_arith_class #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a_u_i,
    input  logic [DW-1:0] b_u_i,
    input  logic [DW-1:0] r_u_i,
    input  logic          a_neg_i,
    input  logic          a_zero_i,
    input  logic          b_neg_i,
    input  logic          b_zero_i,
    input  logic          r_neg_i,
    input  logic          r_zero_i,
    output logic [1:0]    sadd_o,
    output logic [1:0]    ssub_o,
    output logic [1:0]    uadd_o,
    output logic [1:0]    usub_o
);
    import cc_gen_pkg::*;

    logic a_pos, b_pos, r_pos;
    logic add_ovf, sub_ovf, carry;
    logic [1:0] sign_code;

    // Purpose: find the strictly positive operands.
    always_comb begin
        a_pos = !a_neg_i && !a_zero_i;
        b_pos = !b_neg_i && !b_zero_i;
        r_pos = !r_neg_i && !r_zero_i;
    end

    // Purpose: code for the result's sign when no overflow is reported.
    always_comb begin
        if (r_neg_i)       sign_code = CODE_LOW;
        else if (r_zero_i) sign_code = CODE_ZERO;
        else               sign_code = CODE_HIGH;
    end

    // Purpose: signed overflow for add and for subtract.
    always_comb begin
        add_ovf = (a_pos && b_pos && r_neg_i) || (a_neg_i && b_neg_i && r_pos);
        sub_ovf = (a_pos && b_neg_i && r_neg_i) || (a_neg_i && b_pos && r_pos);
        sadd_o  = add_ovf ? CODE_SPEC : sign_code;
        ssub_o  = sub_ovf ? CODE_SPEC : sign_code;
    end

    // Purpose: unsigned add carry and unsigned subtract borrow coding.
    always_comb begin
        carry  = (r_u_i < a_u_i) || (r_u_i < b_u_i);
        uadd_o = {carry, !r_zero_i};
        if (r_zero_i)           usub_o = CODE_HIGH;
        else if (b_u_i > a_u_i) usub_o = CODE_LOW;
        else                    usub_o = CODE_SPEC;
    end
endmodule

// File: rtl/cc_unary_class.sv
// Module: cc_unary_class
// Codes the single-operand operations on the result: the nonzero test,
// absolute value, negative absolute value and complement.
// Assumes r_u_i is the zero-extended view and narrow_i matches that view.
module cc_unary_class #(
    parameter int DW = 64,
    parameter int NW = 32
) (
    input  logic [DW-1:0] r_u_i,
    input  logic          r_neg_i,
    input  logic          r_zero_i,
    input  logic          narrow_i,
    output logic [1:0]    nz_o,
    output logic [1:0]    abs_o,
    output logic [1:0]    nabs_o,
    output logic [1:0]    neg_o
);
    import cc_gen_pkg::*;

    localparam logic [DW-1:0] MIN_WIDE   = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MIN_NARROW = {{(DW-NW){1'b0}}, 1'b1, {(NW-1){1'b0}}};

    logic at_min;

    // Purpose: detect the most negative value of the active width.
    always_comb begin
        at_min = narrow_i ? (r_u_i == MIN_NARROW) : (r_u_i == MIN_WIDE);
    end

    // Purpose: derive each unary code from the flags.
    always_comb begin
        nz_o   = r_zero_i ? CODE_ZERO : CODE_LOW;
        nabs_o = r_zero_i ? CODE_ZERO : CODE_LOW;
        if (at_min)        abs_o = CODE_SPEC;
        else if (r_zero_i) abs_o = CODE_ZERO;
        else               abs_o = CODE_LOW;
        if (at_min)        neg_o = CODE_SPEC;
        else if (r_neg_i)  neg_o = CODE_LOW;
        else if (r_zero_i) neg_o = CODE_ZERO;
        else               neg_o = CODE_HIGH;
    end
endmodule

// File: rtl/cond_code_unit.sv
// Module: cond_code_unit (top)
// Decodes the selector, builds width views of the three operands, runs the
// compare, arithmetic and unary classifiers, and picks the code for the
// selected operation. An unknown selector gives code 0 and raises err_o.
// REG_OUT = 1 registers the outputs (one cycle of latency, synchronous
// active-low reset). REG_OUT = 0 leaves the unit purely combinational.
module cond_code_unit #(
    parameter int DW      = 64,
    parameter int NW      = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    sel_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic [DW-1:0] res_i,
    output logic [1:0]    cc_o,
    output logic          err_o
);
    import cc_gen_pkg::*;

    localparam int NOPS = 3;

    cc_sel_e    op;
    logic       narrow;
    logic       sel_valid;
    logic       is_scmp;
    logic [1:0] cc_nxt;
    logic       err_nxt;

    logic [DW-1:0] raw   [NOPS];
    logic [DW-1:0] zext  [NOPS];
    logic [DW-1:0] sext  [NOPS];
    logic          neg   [NOPS];
    logic          zero  [NOPS];

    logic [1:0] ab_code, rz_code;
    logic [1:0] sadd_c, ssub_c, uadd_c, usub_c;
    logic [1:0] nz_c, abs_c, nabs_c, neg_c;

    // Purpose: decode the selector fields.
    always_comb begin
        op        = cc_sel_e'(sel_i);
        narrow    = !sel_i[0];
        sel_valid = (int'(sel_i) <= SEL_LAST);
        is_scmp   = (op == CC_SCMP_W) || (op == CC_SCMP_D);
    end

    // Purpose: gather the operands in a fixed order (a, b, result).
    always_comb begin
        raw[0] = opa_i;
        raw[1] = opb_i;
        raw[2] = res_i;
    end

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_view
        cc_opnd_view #(.DW(DW), .NW(NW)) u_view (
            .raw_i   (raw[gi]),
            .narrow_i(narrow),
            .zext_o  (zext[gi]),
            .sext_o  (sext[gi]),
            .neg_o   (neg[gi]),
            .zero_o  (zero[gi])
        );
    end

    cc_relate #(.DW(DW)) u_cmp_ab (
        .lhs_s_i (sext[0]),
        .rhs_s_i (sext[1]),
        .lhs_u_i (zext[0]),
        .rhs_u_i (zext[1]),
        .signed_i(is_scmp),
        .code_o  (ab_code)
    );

    cc_relate #(.DW(DW)) u_cmp_zero (
        .lhs_s_i (sext[2]),
        .rhs_s_i ('0),
        .lhs_u_i (zext[2]),
        .rhs_u_i ('0),
        .signed_i(1'b1),
        .code_o  (rz_code)
    );

    cc_arith_class #(.DW(DW)) u_arith (
        .a_u_i   (zext[0]),
        .b_u_i   (zext[1]),
        .r_u_i   (zext[2]),
        .a_neg_i (neg[0]),
        .a_zero_i(zero[0]),
        .b_neg_i (neg[1]),
        .b_zero_i(zero[1]),
        .r_neg_i (neg[2]),
        .r_zero_i(zero[2]),
        .sadd_o  (sadd_c),
        .ssub_o  (ssub_c),
        .uadd_o  (uadd_c),
        .usub_o  (usub_c)
    );

    cc_unary_class #(.DW(DW), .NW(NW)) u_unary (
        .r_u_i   (zext[2]),
        .r_neg_i (neg[2]),
        .r_zero_i(zero[2]),
        .narrow_i(narrow),
        .nz_o    (nz_c),
        .abs_o   (abs_c),
        .nabs_o  (nabs_c),
        .neg_o   (neg_c)
    );

    // Purpose: select the code for the requested operation.
    always_comb begin
        err_nxt = 1'b0;
        unique case (op)
            CC_K0, CC_K1, CC_K2, CC_K3:   cc_nxt = sel_i[1:0];
            CC_NZ_W, CC_NZ_D:             cc_nxt = nz_c;
            CC_SCMP_W, CC_SCMP_D,
            CC_UCMP_W, CC_UCMP_D:         cc_nxt = ab_code;
            CC_SZR_W, CC_SZR_D:           cc_nxt = rz_code;
            CC_SADD_W, CC_SADD_D:         cc_nxt = sadd_c;
            CC_SSUB_W, CC_SSUB_D:         cc_nxt = ssub_c;
            CC_UADD_W, CC_UADD_D:         cc_nxt = uadd_c;
            CC_USUB_W, CC_USUB_D:         cc_nxt = usub_c;
            CC_ABS_W, CC_ABS_D:           cc_nxt = abs_c;
            CC_NABS_W, CC_NABS_D:         cc_nxt = nabs_c;
            CC_NEG_W, CC_NEG_D:           cc_nxt = neg_c;
            default: begin
                cc_nxt  = CODE_ZERO;
                err_nxt = 1'b1;
            end
        endcase
    end

    if (REG_OUT) begin : g_reg
        // Purpose: register the code and the flag, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cc_o  <= CODE_ZERO;
                err_o <= 1'b0;
            end else begin
                cc_o  <= cc_nxt;
                err_o <= err_nxt;
            end
        end

        AST_CONST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i <= 5'd3) |=> (cc_o == $past(sel_i[1:0]) && !err_o)); // R1
        AST_BAD_SEL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_valid |=> (err_o && cc_o == 2'd0)); // R12
        AST_GOOD_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid |=> !err_o); // R12
        AST_NZ_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
            (op == CC_NZ_W || op == CC_NZ_D) |=> !cc_o[1]); // R10
        AST_NABS_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
            (op == CC_NABS_W || op == CC_NABS_D) |=> !cc_o[1]); // R8
        AST_USUB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (op == CC_USUB_W || op == CC_USUB_D) |=> (cc_o != 2'd0)); // R7
    end else begin : g_comb
        assign cc_o  = cc_nxt;
        assign err_o = err_nxt;
    end
endmodule

// File: tb/cond_code_unit_test.sv
// Directed bench for cond_code_unit. Each scenario task checks its own results.
module cond_code_unit_test;

    localparam logic [63:0] ALL1  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sel = '0;
    logic [63:0] opa = '0, opb = '0, res = '0;
    logic [1:0]  cc;
    logic        err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cond_code_unit uut (
        .clk  (clk),
        .rst_n(rst_n),
        .sel_i(sel),
        .opa_i(opa),
        .opb_i(opb),
        .res_i(res),
        .cc_o (cc),
        .err_o(err)
    );

    task automatic compare(input string tag, input logic [1:0] exp_cc, input logic exp_err);
        n_checks++;
        if (cc !== exp_cc || err !== exp_err) begin
            n_fail++;
            $display("FAIL %s: sel=%0d cc=%0d expected %0d, err=%0b expected %0b",
                     tag, sel, cc, exp_cc, err, exp_err);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic apply(input string tag, input logic [4:0] s, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] r,
                         input logic [1:0] exp_cc, input logic exp_err = 1'b0);
        @(negedge clk);
        sel = s; opa = a; opb = b; res = r;
        @(negedge clk);
        compare(tag, exp_cc, exp_err);
    endtask

    task automatic t_reset;  // R13
        @(negedge clk);
        sel = 5'd31; opa = ALL1;
        repeat (3) @(negedge clk);
        compare("R13 reset", 2'd0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;  // R13
        apply("R13 setup", 5'd0, '0, '0, '0, 2'd0);
        @(negedge clk);
        sel = 5'd2;
        #5 compare("R13 before edge", 2'd0, 1'b0);
        @(negedge clk);
        compare("R13 after edge", 2'd2, 1'b0);
    endtask

    task automatic t_const;  // R1
        for (int k = 0; k < 4; k++)
            apply("R1 constant", 5'(k), ALL1, MIN64, 64'h5, 2'(k));
    endtask

    task automatic t_compare;  // R2 and R11
        apply("R2 scmp eq",   5'd7, 64'd5, 64'd5, '0, 2'd0);
        apply("R2 scmp lt",   5'd7, ALL1, 64'd1, '0, 2'd1);
        apply("R2 scmp gt",   5'd7, 64'd1, ALL1, '0, 2'd2);
        apply("R2 ucmp gt",   5'd9, ALL1, 64'd1, '0, 2'd2);
        apply("R2 ucmp32 lt", 5'd8, 64'd3, 64'd7, '0, 2'd1);
        apply("R2 scmp32 lt", 5'd6, 64'h8000_0000, 64'h7FFF_FFFF, '0, 2'd1);
        apply("R2 ucmp32 gt", 5'd8, 64'h8000_0000, 64'h7FFF_FFFF, '0, 2'd2);
        apply("R11 scmp32 upper ignored", 5'd6, 64'hFFFF_FFFF_0000_0005, 64'd5, '0, 2'd0);
    endtask

    task automatic t_zero_cmp;  // R3
        apply("R3 neg",      5'd11, '0, '0, 64'hFFFF_FFFF_FFFF_FFFB, 2'd1);
        apply("R3 zero",     5'd11, '0, '0, '0, 2'd0);
        apply("R3 neg32",    5'd10, '0, '0, 64'h0000_0000_8000_0000, 2'd1);
        apply("R3 pos32",    5'd10, '0, '0, 64'h1234_0000_0000_0001, 2'd2);
    endtask

    task automatic t_sadd;  // R4
        apply("R4 pos ovf",  5'd13, MAX64, 64'd1, MIN64, 2'd3);
        apply("R4 neg ovf",  5'd13, MIN64, ALL1, MAX64, 2'd3);
        apply("R4 neg",      5'd13, ALL1, ALL1, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1);
        apply("R4 zero",     5'd13, 64'd5, 64'hFFFF_FFFF_FFFF_FFFB, '0, 2'd0);
        apply("R4 pos",      5'd13, 64'd3, 64'd4, 64'd7, 2'd2);
        apply("R4 ovf32",    5'd12, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd3);
    endtask

    task automatic t_ssub;  // R5
        apply("R5 ovf",      5'd15, MAX64, ALL1, MIN64, 2'd3);
        apply("R5 mirror",   5'd15, MIN64, 64'd1, MAX64, 2'd3);
        apply("R5 neg",      5'd15, 64'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1);
        apply("R5 pos",      5'd15, 64'd9, 64'd2, 64'd7, 2'd2);
        apply("R5 zero32",   5'd14, 64'd3, 64'd3, 64'hABCD_0000_0000_0000, 2'd0);
    endtask

    task automatic t_uadd;  // R6
        apply("R6 zero nc",  5'd17, '0, '0, '0, 2'd0);
        apply("R6 zero c",   5'd17, ALL1, 64'd1, '0, 2'd2);
        apply("R6 nz nc",    5'd17, 64'd2, 64'd3, 64'd5, 2'd1);
        apply("R6 nz c",     5'd17, ALL1, 64'd2, 64'd1, 2'd3);
        apply("R6 zero c32", 5'd16, 64'hFFFF_FFFF, 64'd1, 64'h1_0000_0000, 2'd2);
    endtask

    task automatic t_usub;  // R7 and R11
        apply("R7 zero",     5'd19, 64'd7, 64'd7, '0, 2'd2);
        apply("R7 borrow",   5'd19, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1);
        apply("R7 no borrow",5'd19, 64'd9, 64'd4, 64'd5, 2'd3);
        apply("R11 usub32 borrow", 5'd18, 64'h1_0000_0003, 64'd5, 64'hFFFF_FFFE, 2'd1);
    endtask

    task automatic t_abs;  // R8 and R11
        apply("R8 abs min",   5'd21, '0, '0, MIN64, 2'd3);
        apply("R8 abs nz",    5'd21, '0, '0, 64'd5, 2'd1);
        apply("R8 abs zero",  5'd21, '0, '0, '0, 2'd0);
        apply("R8 abs min32", 5'd20, '0, '0, 64'h0000_0000_8000_0000, 2'd3);
        apply("R11 abs32 upper ignored", 5'd20, '0, '0, 64'hFFFF_FFFF_0000_0000, 2'd0);
        apply("R8 nabs zero", 5'd23, '0, '0, '0, 2'd0);
        apply("R8 nabs nz",   5'd23, '0, '0, 64'hFFFF_FFFF_FFFF_FFFD, 2'd1);
        apply("R8 nabs32 zero", 5'd22, '0, '0, 64'hABCD_0000_0000_0000, 2'd0);
    endtask

    task automatic t_neg;  // R9
        apply("R9 min",      5'd25, '0, '0, MIN64, 2'd3);
        apply("R9 neg",      5'd25, '0, '0, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1);
        apply("R9 pos",      5'd25, '0, '0, 64'd2, 2'd2);
        apply("R9 zero",     5'd25, '0, '0, '0, 2'd0);
        apply("R9 min32",    5'd24, '0, '0, 64'h8000_0000, 2'd3);
        apply("R9 neg32",    5'd24, '0, '0, 64'h0000_0000_FFFF_FFFE, 2'd1);
    endtask

    task automatic t_nz;  // R10 and R11
        apply("R10 zero",    5'd5, ALL1, ALL1, '0, 2'd0);
        apply("R10 nonzero", 5'd5, '0, '0, 64'h1_0000_0000, 2'd1);
        apply("R11 nz32 upper ignored", 5'd4, '0, '0, 64'h1_0000_0000, 2'd0);
    endtask

    task automatic t_bad_sel;  // R12
        apply("R12 sel 26",  5'd26, ALL1, ALL1, ALL1, 2'd0, 1'b1);
        apply("R12 sel 31",  5'd31, MIN64, 64'd1, 64'd2, 2'd0, 1'b1);
        apply("R12 recover", 5'd3, '0, '0, '0, 2'd3, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports the summary.
    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_const();
        t_compare();
        t_zero_cmp();
        t_sadd();
        t_ssub();
        t_uadd();
        t_usub();
        t_abs();
        t_neg();
        t_nz();
        t_bad_sel();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule